// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Lookup

This block models the tag side of a direct-mapped cache. Every accepted request carries a 32-bit word address. The block splits that address into a line index and a tag, looks up the line, and one cycle later reports whether the access hit. It returns the computed tag and index with that result. On a miss the line is filled with the new tag in the same clock edge that registers the result. The next request to that line therefore already sees the new contents.

Parameters set the number of words per block and the number of lines. A mode parameter picks how the line index is formed. The first choice is the usual low-order field of the block address, which is the block address modulo the line count. The second choice folds two upper fields of the block address together with XOR. In the folded mode the index bits no longer rebuild the address, so the whole block address is kept as the tag. The block is meant for studying miss behaviour of address streams across cache shapes, such as 16 lines of one word, 8 lines of two words, or 2 lines of four words.

Top module: `dm_tag_ctrl`

## Requirements
- R1: After any reset every line is invalid, so the first access to each line after reset reports a miss.
- R2: `req_ready_o` is low while reset is asserted and high from the first clock edge after reset is released.
- R3: A request is accepted when `req_valid_i` and `req_ready_o` are both high at a rising edge. Exactly one result with `rsp_valid_o` high follows, one cycle after acceptance.
- R4: In modulo mode (`IDX_MODE` = 0), the index is the block address modulo `NUM_BLKS`. The block address is the word address shifted right by log2(`WORDS_PER_BLK`). `rsp_tag_o` is the block address shifted right by log2(`NUM_BLKS`), zero-extended to 32 bits.
- R5: In fold mode (`IDX_MODE` = 1), the block address is zero-extended to 32 bits and the index is its top IDX_W bits XOR the next IDX_W bits below them. With 32 lines this is block address bits [31:27] XOR bits [26:22]. `rsp_tag_o` is the full block address.
- R6: `rsp_hit_o` is high exactly when the indexed line was valid and its stored tag equalled the request tag before the request was accepted.
- R7: A miss stores the request tag in the indexed line and marks the line valid. An immediately following request to the same block hits, and a request to a different block with the same index evicts the line.
- R8: With multi-word blocks, every word address in a filled block hits, whatever its offset inside the block.
- R9: In a cycle after which no request was accepted, `rsp_valid_o` and `rsp_hit_o` are low and `rsp_tag_o` and `rsp_index_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | ADDR_W | Word address of the request |
| rsp_valid_o | output | 1 | Result strobe, one per accepted request |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_tag_o | output | ADDR_W | Tag computed for the request, zero-extended |
| rsp_index_o | output | log2(NUM_BLKS) | Line index computed for the request |

## Verification
On every cycle the assertions check the result timing against acceptance and the idle hold of tag and index. They also check that a repeated back-to-back address hits and that ready is high after reset. Correct hit or miss decisions over long histories, eviction on conflicts, and the index and tag arithmetic in both modes need a reference model. The bench shows these by running the same address streams through four shapes at once (16x1, 8x2 and 2x4 modulo, 32x1 folded) and comparing every result field. Sweeps of low addresses, fixed mixed streams, deliberate fold collisions, pseudo-random full-width addresses and a reset in the middle of the run cover the empty-after-reset rule.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic {
    IDX_MODULO   = 1'b0,
    IDX_XOR_FOLD = 1'b1
  } idx_mode_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split
  import dmc_pkg::*;
#(
  parameter int        ADDR_W = 32,
  parameter int        OFF_W  = 0,
  parameter int        IDX_W  = 4,
  parameter int        TAG_W  = 28,
  parameter idx_mode_e MODE   = IDX_MODULO
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [ADDR_W-1:0] blk_addr;

  assign blk_addr = addr_i >> OFF_W;

  generate
    if (MODE == IDX_XOR_FOLD) begin : g_fold
      // two adjacent upper fields of the zero-extended block address
      assign idx_o = blk_addr[ADDR_W-1 -: IDX_W] ^ blk_addr[ADDR_W-1-IDX_W -: IDX_W];
      assign tag_o = blk_addr[TAG_W-1:0];
    end else begin : g_mod
      assign idx_o = blk_addr[IDX_W-1:0];
      assign tag_o = blk_addr[IDX_W +: TAG_W];
    end
  endgenerate
endmodule

// File: rtl/dmc_line_array.sv
module dmc_line_array #(
  parameter int LINES = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  output logic             lk_valid_o,
  output logic [TAG_W-1:0] lk_tag_o
);
  logic [LINES-1:0] vld_w;
  logic [TAG_W-1:0] tag_w [LINES];

  generate
    for (genvar l = 0; l < LINES; l++) begin : g_line
      logic             wr_en;
      logic             v_q;
      logic [TAG_W-1:0] t_q;

      assign wr_en = fill_i && (lk_idx_i == IDX_W'(l));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
        end else if (wr_en) begin
          v_q <= 1'b1;
        end
      end

      // tag storage needs no reset: it is only read through a valid line
      always_ff @(posedge clk) begin
        if (wr_en) begin
          t_q <= fill_tag_i;
        end
      end

      assign vld_w[l] = v_q;
      assign tag_w[l] = t_q;
    end
  endgenerate

  assign lk_valid_o = vld_w[lk_idx_i];
  assign lk_tag_o   = tag_w[lk_idx_i];
endmodule

// File: rtl/dm_tag_ctrl.sv
module dm_tag_ctrl
  import dmc_pkg::*;
#(
  parameter int        ADDR_W        = 32,
  parameter int        WORDS_PER_BLK = 1,
  parameter int        NUM_BLKS      = 16,
  parameter idx_mode_e IDX_MODE      = IDX_MODULO
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [ADDR_W-1:0]           req_addr_i,
  output logic                        rsp_valid_o,
  output logic                        rsp_hit_o,
  output logic [ADDR_W-1:0]           rsp_tag_o,
  output logic [$clog2(NUM_BLKS)-1:0] rsp_index_o
);
  localparam int OFF_W = $clog2(WORDS_PER_BLK);
  localparam int IDX_W = $clog2(NUM_BLKS);
  localparam int TAG_W = (IDX_MODE == IDX_XOR_FOLD) ? (ADDR_W - OFF_W)
                                                    : (ADDR_W - OFF_W - IDX_W);

  logic             rdy_q;
  logic             accept;
  logic [IDX_W-1:0] cur_idx;
  logic [TAG_W-1:0] cur_tag;
  logic             line_vld;
  logic [TAG_W-1:0] line_tag;
  logic             match;
  logic             fill;

  logic              vld_d, vld_q;
  logic              hit_d, hit_q;
  logic [ADDR_W-1:0] tag_d, tag_q;
  logic [IDX_W-1:0]  idx_d, idx_q;

  dmc_addr_split #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .MODE   (IDX_MODE)
  ) u_split (
    .addr_i (req_addr_i),
    .idx_o  (cur_idx),
    .tag_o  (cur_tag)
  );

  dmc_line_array #(
    .LINES (NUM_BLKS),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_idx_i   (cur_idx),
    .fill_i     (fill),
    .fill_tag_i (cur_tag),
    .lk_valid_o (line_vld),
    .lk_tag_o   (line_tag)
  );

  assign accept = req_valid_i && rdy_q;
  assign match  = line_vld && (line_tag == cur_tag);
  assign fill   = accept && !match;

  // next-state logic
  always_comb begin
    vld_d = accept;
    hit_d = accept && match;
    tag_d = tag_q;
    idx_d = idx_q;
    if (accept) begin
      tag_d = ADDR_W'(cur_tag);
      idx_d = cur_idx;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      vld_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      vld_q <= vld_d;
      hit_q <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      idx_q <= '0;
    end else if (accept) begin
      tag_q <= tag_d;
      idx_q <= idx_d;
    end
  end

  assign req_ready_o = rdy_q;
  assign rsp_valid_o = vld_q;
  assign rsp_hit_o   = hit_q;
  assign rsp_tag_o   = tag_q;
  assign rsp_index_o = idx_q;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [ADDR_W-1:0] rsp_tag,
  input logic [IDX_W-1:0]  rsp_index
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R3
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(rsp_tag) && $stable(rsp_index) && !rsp_hit));

  // R7
  repeat_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && $past(acc) && (req_addr == $past(req_addr))) |=> rsp_hit);

  // R2
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> req_ready);
endmodule

bind dm_tag_ctrl dmc_checker #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) u_dmc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid_i),
  .req_ready (req_ready_o),
  .req_addr  (req_addr_i),
  .rsp_valid (rsp_valid_o),
  .rsp_hit   (rsp_hit_o),
  .rsp_tag   (rsp_tag_o),
  .rsp_index (rsp_index_o)
);

// File: tb/test_dm_tag_ctrl.sv
module test_dm_tag_ctrl;
  import dmc_pkg::*;

  localparam int NCFG = 4;
  // shapes: 16x1 modulo, 8x2 modulo, 2x4 modulo, 32x1 fold
  localparam int OFF_C [NCFG] = '{0, 1, 2, 0};
  localparam int IDW_C [NCFG] = '{4, 3, 1, 5};
  localparam bit FLD_C [NCFG] = '{1'b0, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [31:0] req_addr;
  logic [NCFG-1:0] rdy, rv, hit;
  logic [31:0] tg [NCFG];
  logic [NCFG-1:0][4:0] ix;

  int n_cmp = 0;
  int n_bad = 0;

  bit          mv [NCFG][32];
  logic [31:0] mt [NCFG][32];

  always #10 clk = ~clk;

  dm_tag_ctrl #(.WORDS_PER_BLK(1), .NUM_BLKS(16), .IDX_MODE(IDX_MODULO)) i_dm_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy[0]),
    .req_addr_i(req_addr), .rsp_valid_o(rv[0]), .rsp_hit_o(hit[0]),
    .rsp_tag_o(tg[0]), .rsp_index_o(ix[0][3:0]));
  assign ix[0][4] = 1'b0;

  dm_tag_ctrl #(.WORDS_PER_BLK(2), .NUM_BLKS(8), .IDX_MODE(IDX_MODULO)) i_dm_tag_ctrl_b (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy[1]),
    .req_addr_i(req_addr), .rsp_valid_o(rv[1]), .rsp_hit_o(hit[1]),
    .rsp_tag_o(tg[1]), .rsp_index_o(ix[1][2:0]));
  assign ix[1][4:3] = 2'b00;

  dm_tag_ctrl #(.WORDS_PER_BLK(4), .NUM_BLKS(2), .IDX_MODE(IDX_MODULO)) i_dm_tag_ctrl_c (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy[2]),
    .req_addr_i(req_addr), .rsp_valid_o(rv[2]), .rsp_hit_o(hit[2]),
    .rsp_tag_o(tg[2]), .rsp_index_o(ix[2][0:0]));
  assign ix[2][4:1] = 4'b0000;

  dm_tag_ctrl #(.WORDS_PER_BLK(1), .NUM_BLKS(32), .IDX_MODE(IDX_XOR_FOLD)) i_dm_tag_ctrl_d (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy[3]),
    .req_addr_i(req_addr), .rsp_valid_o(rv[3]), .rsp_hit_o(hit[3]),
    .rsp_tag_o(tg[3]), .rsp_index_o(ix[3]));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_idx(input int c, input logic [31:0] a);
    logic [31:0] ba;
    logic [31:0] mask;
    ba   = a >> OFF_C[c];
    mask = (32'd1 << IDW_C[c]) - 32'd1;
    if (FLD_C[c]) return ((ba >> (32 - IDW_C[c])) ^ (ba >> (32 - 2 * IDW_C[c]))) & mask;
    return ba & mask;
  endfunction

  function automatic logic [31:0] exp_tag(input int c, input logic [31:0] a);
    logic [31:0] ba;
    ba = a >> OFF_C[c];
    if (FLD_C[c]) return ba;
    return ba >> IDW_C[c];
  endfunction

  task automatic clear_model();
    for (int c = 0; c < NCFG; c++)
      for (int l = 0; l < 32; l++) mv[c][l] = 1'b0;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic access(input logic [31:0] a, input string rq);
    logic [31:0] ei [NCFG];
    logic [31:0] et [NCFG];
    bit          eh [NCFG];
    req_valid = 1'b1;
    req_addr  = a;
    for (int c = 0; c < NCFG; c++) begin
      ei[c] = exp_idx(c, a);
      et[c] = exp_tag(c, a);
      eh[c] = mv[c][ei[c]] && (mt[c][ei[c]] == et[c]);
      mv[c][ei[c]] = 1'b1;
      mt[c][ei[c]] = et[c];
    end
    @(negedge clk);
    for (int c = 0; c < NCFG; c++) begin
      chk(rv[c] == 1'b1, "R3", "rsp_valid", 32'(rv[c]), 32'd1);
      chk(hit[c] == eh[c], rq, "hit (R6)", 32'(hit[c]), 32'(eh[c]));
      chk(tg[c] == et[c], FLD_C[c] ? "R5" : "R4", "tag", tg[c], et[c]);
      chk(32'(ix[c]) == ei[c], FLD_C[c] ? "R5" : "R4", "index", 32'(ix[c]), ei[c]);
    end
  endtask

  task automatic idle();
    logic [31:0] pt [NCFG];
    logic [NCFG-1:0][4:0] pi;
    for (int c = 0; c < NCFG; c++) pt[c] = tg[c];
    pi = ix;
    req_valid = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NCFG; c++) begin
      chk(rv[c] == 1'b0, "R9", "rsp_valid idle", 32'(rv[c]), 32'd0);
      chk(hit[c] == 1'b0, "R9", "hit idle", 32'(hit[c]), 32'd0);
      chk(tg[c] == pt[c], "R9", "tag hold", tg[c], pt[c]);
      chk(ix[c] == pi[c], "R9", "index hold", 32'(ix[c]), 32'(pi[c]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  int list_a [12] = '{1, 134, 212, 1, 135, 213, 162, 161, 2, 44, 41, 221};
  int list_b [12] = '{6, 214, 175, 214, 6, 84, 65, 174, 64, 105, 85, 215};

  initial begin
    logic [31:0] lf;
    logic [31:0] prev;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    clear_model();
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCFG; c++) begin
      chk(rdy[c] == 1'b0, "R2", "ready in reset", 32'(rdy[c]), 32'd0);
      chk(rv[c] == 1'b0, "R2", "rsp_valid in reset", 32'(rv[c]), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCFG; c++)
      chk(rdy[c] == 1'b1, "R2", "ready after reset", 32'(rdy[c]), 32'd1);

    for (int a = 0; a < 32; a++) access(32'(a), "R1");
    for (int a = 0; a < 32; a++) access(32'(a), "R7");
    idle();
    for (int a = 0; a < 64; a++) begin
      access(32'(a), "R8");
      if ((a % 8) == 7) idle();
    end
    for (int k = 0; k < 12; k++) access(32'(list_a[k]), "R6");
    idle();
    for (int k = 0; k < 12; k++) access(32'(list_b[k]), "R6");
    idle();

    // fold collisions: both addresses map to line 1 of the folded shape
    access(32'h0800_0000, "R7");
    access(32'h0040_0000, "R7");
    access(32'h0800_0000, "R7");
    access(32'h0800_0000, "R7");
    access(32'h0840_0000, "R5");
    idle();

    lf = 32'h1357_9bdf;
    prev = 32'd0;
    for (int k = 0; k < 600; k++) begin
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 17);
      lf = lf ^ (lf << 5);
      if ((k % 3) == 2) access(prev, "R7");
      else begin
        access(lf, "R5");
        prev = lf;
      end
      if ((k % 17) == 16) idle();
    end
    idle();

    // reset in mid-run must empty every line
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    @(negedge clk);
    for (int k = 0; k < 12; k++) access(32'(list_a[k]), "R1");
    idle();

    summary();
    $finish;
  end
endmodule